// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This block takes received frames from a byte stream and places them into memory buffers described by a ring of eight-byte descriptors. A frame is stored with a 32-bit checksum appended after its payload. Each descriptor gets at most one buffer's worth of bytes, so a long frame spreads over several descriptors and the checksum may straddle two of them. The block writes back each descriptor's length and status, and then raises a one-cycle event: a buffer event for a descriptor closed in mid-frame, or a frame event for the descriptor that ends the frame.

A descriptor is two 32-bit words. The first word holds the status flags in bits 31:16 and the byte count in bits 15:0. The second word holds the buffer's byte address. The flag bits are empty (flag bit 15), wrap (13), last (11), too-long (5) and truncated (0). A receive-active flag tells whether the descriptor at the current pointer is empty, and the input stream is only accepted while that flag is set. Software fills the ring, loads the ring start, and pulses the activate input to have the block poll the current descriptor again.

The controller walks these named states:
- IDLE leaves to OPEN when a byte arrives while active, or to POLL on an activate pulse while enabled and inactive.
- OPEN reads flag word 0. An empty descriptor goes to FETCH. A full descriptor goes to DISCARD if the frame is still streaming, otherwise to POLL.
- FETCH reads the buffer address and goes to TAKE, or to CRC when the payload is complete.
- TAKE accepts one byte and goes to PUT.
- PUT writes that byte and goes to CLOSE when the buffer is full, else to CRC or back to TAKE.
- CRC writes checksum bytes and goes to CLOSE after the fourth byte or when the buffer is full.
- CLOSE writes word 0 back and goes to ADVANCE.
- ADVANCE moves the pointer and goes to OPEN, or at frame end to DISCARD or POLL.
- DISCARD swallows the input up to its last byte and goes to POLL.
- POLL rereads the descriptor at the pointer and goes back to IDLE.

Top module: `rxr_ring_filler`

## Requirements
- R1: The stored frame is the payload followed by four checksum bytes, most significant byte first. The checksum is computed with the reflected polynomial 0x04C11DB7 (0xEDB88320), preset to all ones, over the stored payload, and its final value is inverted.
- R2: When the payload plus checksum would exceed 2032 bytes, only the first 2028 payload bytes are stored, followed by the checksum. The last descriptor then gets the truncated flag (bit 0) and the too-long flag (bit 5). The rest of the input frame is consumed and dropped. A 2028-byte payload is not truncated.
- R3: When the stored size including the checksum is greater than `cfg_max_frame`, the last descriptor gets the too-long flag only. A size equal to the limit sets no flag.
- R4: Each descriptor receives min(remaining bytes, 16 × `cfg_max_buf_blocks`) bytes, and that count is written into bits 15:0 of word 0. A value of zero places the whole frame in one buffer.
- R5: Closing a descriptor clears the empty flag (bit 15) and keeps the other flags it had. The final descriptor also gets the last flag (bit 11) and the frame's error flags. A final close pulses `evt_rx_frame` for one cycle after the write; any other close pulses `evt_rx_buf` instead.
- R6: After a descriptor is closed, the pointer returns to the ring start if the wrap flag (bit 13) is set, and otherwise advances by 8 bytes.
- R7: When a non-empty descriptor is reached in mid-frame, the rest of the frame is dropped. Nothing more is written and no frame event is raised.
- R8: After each frame, and on an activate pulse while enabled and inactive, `rx_active` takes the empty flag of the descriptor at the pointer. It drops in the cycle after `enable` goes low.
- R9: While `rx_active` is 0 in IDLE, `s_ready` stays low and no memory access is made.
- R10: A memory request holds its address and direction until it is acknowledged. A byte write uses a single strobe, on lane `mem_addr[1:0]`, with the byte at bits 8·lane+7:8·lane. A descriptor write uses all four strobes.
- R11: A `ring_load` pulse in IDLE sets the pointer to the byte address `cfg_ring_base`·4.
- R12: After reset, `rx_active`, `s_ready`, `mem_req` and both events are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Receive enable; low clears `rx_active` |
| rx_activate | input | 1 | Pulse: poll the current descriptor |
| ring_load | input | 1 | Pulse: load the pointer from the ring start |
| cfg_ring_base | input | 30 | Ring start, as a word address |
| cfg_max_buf_blocks | input | 7 | Buffer size in 16-byte units |
| cfg_max_frame | input | 16 | Soft frame-length limit in bytes |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_ready | output | 1 | Stream byte accepted |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte-lane strobes |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| rx_active | output | 1 | The descriptor at the pointer is empty |
| evt_rx_buf | output | 1 | Pulse: a buffer was closed in mid-frame |
| evt_rx_frame | output | 1 | Pulse: a frame was completed |

## Verification
The hardest case to reach is a frame that runs into a descriptor already owned by software part-way through. The stimulus gets there by clearing the empty flag of the second descriptor and sending a frame that needs several buffers. Checksum bytes that straddle two buffers come from frames sized so that the payload ends two bytes short of a buffer boundary. The truncation boundary is reached with payloads of 2028 and 2040 bytes. The memory model withholds its acknowledge one cycle in four, so every request has to wait at some point.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPEN,
        ST_FETCH,
        ST_TAKE,
        ST_PUT,
        ST_CRC,
        ST_CLOSE,
        ST_ADVANCE,
        ST_DISCARD,
        ST_POLL
    } rxr_state_e;

    // Flag positions inside the upper half of descriptor word 0
    localparam int FLG_EMPTY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;
    localparam int FLG_LONG  = 5;
    localparam int FLG_TRUNC = 0;

    localparam int          CRC_BYTES = 4;
    localparam logic [31:0] CRC_REFL  = 32'hEDB8_8320;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxr_crc32.sv
module rxr_crc32
    import rxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);

    logic [31:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '1;
        end else if (clear) begin
            state_q <= '1;
        end else if (en) begin
            state_q <= crc_step(state_q, din);
        end
    end

    assign fcs = ~state_q;

endmodule

// File: rtl/rxr_ctl.sv
module rxr_ctl
    import rxr_pkg::*;
#(
    parameter int MAX_FRAME   = 2032,
    parameter int DESC_STRIDE = 8,
    parameter int LEN_W       = $clog2(MAX_FRAME + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        rx_activate,
    input  logic        ring_load,
    input  logic [31:2] cfg_ring_base,
    input  logic [6:0]  cfg_max_buf_blocks,
    input  logic [15:0] cfg_max_frame,
    input  logic        s_valid,
    input  logic [7:0]  s_data,
    input  logic        s_last,
    output logic        s_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_wstrb,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        rx_active,
    output logic        evt_rx_buf,
    output logic        evt_rx_frame,
    output logic        crc_clear,
    output logic        crc_en,
    output logic [7:0]  crc_din,
    input  logic [31:0] crc_fcs
);

    localparam int              PAY_MAX  = MAX_FRAME - CRC_BYTES;
    localparam logic [LEN_W-1:0] PAY_LAST = LEN_W'(PAY_MAX);
    localparam logic [31:0]     STRIDE   = 32'(DESC_STRIDE);

    rxr_state_e st_q, st_nx;

    logic [31:0]      ptr_q;
    logic [31:0]      buf_q;
    logic [15:0]      flags_q;
    logic [LEN_W-1:0] chunk_q;
    logic [LEN_W-1:0] tot_q;
    logic [LEN_W-1:0] pcnt_q;
    logic [1:0]       crc_idx_q;
    logic [7:0]       byte_q;
    logic             open_q;
    logic             trunc_q;
    logic             final_q;
    logic             evt_b_q;
    logic             evt_f_q;

    logic [15:0]      buf_bytes;
    logic [LEN_W-1:0] chunk_nx;
    logic             buf_full;
    logic             pay_done;
    logic             take;
    logic             start;
    logic             long_flag;
    logic [15:0]      flags_out;
    logic [7:0]       crc_byte;
    logic [31:0]      ring_addr;

    assign buf_bytes = {5'd0, cfg_max_buf_blocks, 4'd0};
    assign chunk_nx  = chunk_q + 1'b1;
    assign buf_full  = (buf_bytes != 16'd0) && (16'(chunk_nx) == buf_bytes);
    assign pay_done  = !open_q || trunc_q;
    assign take      = (st_q == ST_TAKE) && s_valid;
    assign start     = (st_q == ST_IDLE) && rx_active && s_valid;
    assign ring_addr = {cfg_ring_base, 2'b00};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (rx_active && s_valid) begin
                    st_nx = ST_OPEN;
                end else if (rx_activate && enable && !rx_active) begin
                    st_nx = ST_POLL;
                end
            end
            ST_OPEN: begin
                if (mem_ack) begin
                    if (mem_rdata[16 + FLG_EMPTY]) begin
                        st_nx = ST_FETCH;
                    end else begin
                        st_nx = open_q ? ST_DISCARD : ST_POLL;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    st_nx = pay_done ? ST_CRC : ST_TAKE;
                end
            end
            ST_TAKE: begin
                if (s_valid) begin
                    st_nx = ST_PUT;
                end
            end
            ST_PUT: begin
                if (mem_ack) begin
                    if (buf_full) begin
                        st_nx = ST_CLOSE;
                    end else begin
                        st_nx = pay_done ? ST_CRC : ST_TAKE;
                    end
                end
            end
            ST_CRC: begin
                if (mem_ack && (crc_idx_q == 2'd3 || buf_full)) begin
                    st_nx = ST_CLOSE;
                end
            end
            ST_CLOSE: begin
                if (mem_ack) begin
                    st_nx = ST_ADVANCE;
                end
            end
            ST_ADVANCE: begin
                if (final_q) begin
                    st_nx = open_q ? ST_DISCARD : ST_POLL;
                end else begin
                    st_nx = ST_OPEN;
                end
            end
            ST_DISCARD: begin
                if (s_valid && s_last) begin
                    st_nx = ST_POLL;
                end
            end
            ST_POLL: begin
                if (mem_ack) begin
                    st_nx = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            buf_q     <= '0;
            flags_q   <= '0;
            chunk_q   <= '0;
            tot_q     <= '0;
            pcnt_q    <= '0;
            crc_idx_q <= '0;
            byte_q    <= '0;
            open_q    <= 1'b0;
            trunc_q   <= 1'b0;
            final_q   <= 1'b0;
            evt_b_q   <= 1'b0;
            evt_f_q   <= 1'b0;
        end else begin
            evt_b_q <= 1'b0;
            evt_f_q <= 1'b0;
            if (st_q == ST_IDLE && ring_load) begin
                ptr_q <= ring_addr;
            end
            if (start) begin
                open_q    <= 1'b1;
                trunc_q   <= 1'b0;
                final_q   <= 1'b0;
                tot_q     <= '0;
                pcnt_q    <= '0;
                crc_idx_q <= '0;
            end
            if (st_q == ST_OPEN && mem_ack && mem_rdata[16 + FLG_EMPTY]) begin
                flags_q <= mem_rdata[31:16];
            end
            if (st_q == ST_FETCH && mem_ack) begin
                buf_q   <= mem_rdata;
                chunk_q <= '0;
            end
            if (take) begin
                byte_q <= s_data;
                pcnt_q <= pcnt_q + 1'b1;
                if (s_last) begin
                    open_q <= 1'b0;
                end else if (pcnt_q + 1'b1 == PAY_LAST) begin
                    trunc_q <= 1'b1;
                end
            end
            if ((st_q == ST_PUT || st_q == ST_CRC) && mem_ack) begin
                chunk_q <= chunk_nx;
                tot_q   <= tot_q + 1'b1;
            end
            if (st_q == ST_CRC && mem_ack) begin
                crc_idx_q <= crc_idx_q + 1'b1;
                if (crc_idx_q == 2'd3) begin
                    final_q <= 1'b1;
                end
            end
            if (st_q == ST_CLOSE && mem_ack) begin
                evt_f_q <= final_q;
                evt_b_q <= !final_q;
            end
            if (st_q == ST_ADVANCE) begin
                ptr_q <= flags_q[FLG_WRAP] ? ring_addr : ptr_q + STRIDE;
            end
            if (st_q == ST_DISCARD && s_valid && s_last) begin
                open_q <= 1'b0;
            end
        end
    end

    // receive-active flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_active <= 1'b0;
        end else if (!enable) begin
            rx_active <= 1'b0;
        end else if (st_q == ST_POLL && mem_ack) begin
            rx_active <= mem_rdata[16 + FLG_EMPTY];
        end
    end

    always_comb begin
        unique case (crc_idx_q)
            2'd0: crc_byte = crc_fcs[31:24];
            2'd1: crc_byte = crc_fcs[23:16];
            2'd2: crc_byte = crc_fcs[15:8];
            default: crc_byte = crc_fcs[7:0];
        endcase
    end

    assign long_flag = trunc_q || (16'(tot_q) > cfg_max_frame);

    always_comb begin
        flags_out = flags_q & ~(16'h1 << FLG_EMPTY);
        if (final_q) begin
            flags_out = flags_out | (16'h1 << FLG_LAST)
                      | (16'(long_flag) << FLG_LONG)
                      | (16'(trunc_q) << FLG_TRUNC);
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = '0;
        mem_wstrb = 4'h0;
        s_ready   = 1'b0;
        unique case (st_q)
            ST_OPEN, ST_POLL: begin
                mem_req = 1'b1;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + 32'd4;
            end
            ST_PUT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_q + 32'(chunk_q);
                mem_wdata = {4{byte_q}};
                mem_wstrb = 4'h1 << mem_addr[1:0];
            end
            ST_CRC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_q + 32'(chunk_q);
                mem_wdata = {4{crc_byte}};
                mem_wstrb = 4'h1 << mem_addr[1:0];
            end
            ST_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {flags_out, 16'(chunk_q)};
                mem_wstrb = 4'hF;
            end
            ST_TAKE, ST_DISCARD: begin
                s_ready = 1'b1;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    assign evt_rx_buf   = evt_b_q;
    assign evt_rx_frame = evt_f_q;
    assign crc_clear    = start;
    assign crc_en       = take;
    assign crc_din      = s_data;

endmodule

// File: rtl/rxr_ring_filler.sv
module rxr_ring_filler #(
    parameter int MAX_FRAME   = 2032,
    parameter int DESC_STRIDE = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        rx_activate,
    input  logic        ring_load,
    input  logic [31:2] cfg_ring_base,
    input  logic [6:0]  cfg_max_buf_blocks,
    input  logic [15:0] cfg_max_frame,
    input  logic        s_valid,
    input  logic [7:0]  s_data,
    input  logic        s_last,
    output logic        s_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_wstrb,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        rx_active,
    output logic        evt_rx_buf,
    output logic        evt_rx_frame
);

    logic        crc_clear;
    logic        crc_en;
    logic [7:0]  crc_din;
    logic [31:0] crc_fcs;

    rxr_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .en    (crc_en),
        .din   (crc_din),
        .fcs   (crc_fcs)
    );

    rxr_ctl #(
        .MAX_FRAME   (MAX_FRAME),
        .DESC_STRIDE (DESC_STRIDE)
    ) u_ctl (
        .clk                (clk),
        .rst_n              (rst_n),
        .enable             (enable),
        .rx_activate        (rx_activate),
        .ring_load          (ring_load),
        .cfg_ring_base      (cfg_ring_base),
        .cfg_max_buf_blocks (cfg_max_buf_blocks),
        .cfg_max_frame      (cfg_max_frame),
        .s_valid            (s_valid),
        .s_data             (s_data),
        .s_last             (s_last),
        .s_ready            (s_ready),
        .mem_req            (mem_req),
        .mem_we             (mem_we),
        .mem_addr           (mem_addr),
        .mem_wdata          (mem_wdata),
        .mem_wstrb          (mem_wstrb),
        .mem_ack            (mem_ack),
        .mem_rdata          (mem_rdata),
        .rx_active          (rx_active),
        .evt_rx_buf         (evt_rx_buf),
        .evt_rx_frame       (evt_rx_frame),
        .crc_clear          (crc_clear),
        .crc_en             (crc_en),
        .crc_din            (crc_din),
        .crc_fcs            (crc_fcs)
    );

endmodule

// File: rtl/rxr_ring_filler_chk.sv
module rxr_ring_filler_chk #(
    parameter int MAX_FRAME = 2032
) (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        s_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [3:0]  mem_wstrb,
    input logic        mem_ack,
    input logic        rx_active,
    input logic        evt_rx_buf,
    input logic        evt_rx_frame
);

    logic desc_wr;
    assign desc_wr = mem_req && mem_we && (mem_wstrb == 4'hF);

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_rx_buf && evt_rx_frame)); // R5

    AST_CLOSE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr |-> !mem_wdata[31]); // R5

    AST_FRAME_AFTER_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_frame |-> $past(desc_wr && mem_ack && mem_wdata[27])); // R5

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr |-> (mem_wdata[15:0] != 16'd0 && mem_wdata[15:0] <= 16'(MAX_FRAME))); // R4

    AST_TRUNC_HAS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && mem_wdata[16]) |-> (mem_wdata[21] && mem_wdata[27])); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wstrb != 4'hF) |->
            ($countones(mem_wstrb) == 1 && mem_wstrb[mem_addr[1:0]])); // R10

    AST_ACTIVE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rx_active); // R8

    AST_READY_NOT_WITH_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !mem_req); // R9

endmodule

bind rxr_ring_filler rxr_ring_filler_chk #(.MAX_FRAME(MAX_FRAME)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .s_ready      (s_ready),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_wstrb    (mem_wstrb),
    .mem_ack      (mem_ack),
    .rx_active    (rx_active),
    .evt_rx_buf   (evt_rx_buf),
    .evt_rx_frame (evt_rx_frame)
);

// File: tb/rxr_ring_filler_tb.sv
module rxr_ring_filler_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;
    localparam int DESC_BASE  = 32'h40;
    localparam int BUF_BASE   = 32'h400;
    localparam int BUF_STEP   = 32'h800;
    localparam int NDESC      = 6;
    localparam int PAY_MAX    = 2028;

    // {payload length, buffer blocks, soft limit, ring size}
    localparam logic [63:0] VECS [10] = '{
        {16'd60,   16'd127, 16'd1518, 16'd6},
        {16'd100,  16'd2,   16'd1518, 16'd6},
        {16'd60,   16'd2,   16'd1518, 16'd2},
        {16'd30,   16'd2,   16'd1518, 16'd6},
        {16'd200,  16'd127, 16'd100,  16'd6},
        {16'd96,   16'd3,   16'd100,  16'd6},
        {16'd2028, 16'd127, 16'd2032, 16'd6},
        {16'd2040, 16'd127, 16'd1518, 16'd6},
        {16'd28,   16'd1,   16'd32,   16'd6},
        {16'd40,   16'd1,   16'd1518, 16'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        rx_activate = 1'b0;
    logic        ring_load = 1'b0;
    logic [31:2] cfg_ring_base = 30'(DESC_BASE >> 2);
    logic [6:0]  cfg_max_buf_blocks = 7'd127;
    logic [15:0] cfg_max_frame = 16'd1518;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = 8'd0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        rx_active;
    logic        evt_rx_buf;
    logic        evt_rx_frame;

    int checks = 0;
    int fails  = 0;
    int nb = 0;
    int nf = 0;
    int nreq = 0;
    logic [1:0]  cyc = 2'd0;
    logic [31:0] mem [0:MEM_WORDS-1];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxr_ring_filler u_dut (.*);

    // memory model, stalls one cycle in four
    assign mem_ack   = mem_req && (cyc != 2'd3);
    assign mem_rdata = mem[mem_addr[13:2]];

    always @(posedge clk) begin
        cyc <= cyc + 2'd1;
        if (mem_req && mem_we && mem_ack) begin
            for (int b = 0; b < 4; b++) begin
                if (mem_wstrb[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
        end
        if (evt_rx_buf) nb <= nb + 1;
        if (evt_rx_frame) nf <= nf + 1;
        if (mem_req) nreq <= nreq + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int j, input int seed);
        return 8'(j * 13 + seed);
    endfunction

    function automatic logic [7:0] get_byte(input int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    function automatic logic [31:0] crc_next(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic init_ring(input int ring);
        for (int k = 0; k < NDESC; k++) begin
            mem[(DESC_BASE + 8*k) >> 2] = {(k == ring - 1) ? 16'hA000 : 16'h8000, 16'd0};
            mem[(DESC_BASE + 8*k + 4) >> 2] = 32'(BUF_BASE + k * BUF_STEP);
        end
    endtask

    task automatic pulse_load_activate();
        @(negedge clk); ring_load = 1'b1;
        @(negedge clk); ring_load = 1'b0; rx_activate = 1'b1;
        @(negedge clk); rx_activate = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            s_valid = 1'b1;
            s_data  = pay(i, seed);
            s_last  = (i == len - 1);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic run_vector(input int len, input int blocks, input int lim, input int ring, input int seed);
        int p, size, mb, n, b0, f0, bad, wait_n;
        bit tr, lg;
        logic [31:0] c, fcs, w, exp_w;
        logic [15:0] fl;
        logic [7:0] eb, ab;
        init_ring(ring);
        cfg_max_buf_blocks = 7'(blocks);
        cfg_max_frame = 16'(lim);
        pulse_load_activate();
        chk(rx_active == 1'b1, "R8 activate polls empty descriptor", {31'd0, rx_active}, 32'd1);
        b0 = nb; f0 = nf;
        send_frame(len, seed);
        wait_n = 0;
        while (nf == f0 && wait_n < 20000) begin @(negedge clk); wait_n++; end
        repeat (10) @(negedge clk);
        p    = (len > PAY_MAX) ? PAY_MAX : len;
        tr   = (len > PAY_MAX);
        size = p + 4;
        lg   = tr || (size > lim);
        mb   = blocks * 16;
        n    = (size + mb - 1) / mb;
        c = 32'hFFFFFFFF;
        for (int j = 0; j < p; j++) c = crc_next(c, pay(j, seed));
        fcs = ~c;
        for (int k = 0; k < n; k++) begin
            fl = 16'h0;
            if (k == ring - 1) fl = fl | 16'h2000;
            if (k == n - 1) fl = fl | 16'h0800 | (lg ? 16'h0020 : 16'h0) | (tr ? 16'h0001 : 16'h0);
            exp_w = {fl, 16'((k == n - 1) ? size - k * mb : mb)};
            w = mem[(DESC_BASE + 8*k) >> 2];
            chk(w == exp_w, "R4 R5 R2 R3 descriptor word", w, exp_w);
        end
        chk(nf - f0 == 1 && nb - b0 == n - 1, "R5 event counts",
            32'((nf - f0) * 256 + nb - b0), 32'(256 + n - 1));
        bad = 0; ab = 0; eb = 0;
        for (int j = 0; j < size; j++) begin
            logic [7:0] e, a;
            e = (j < p) ? pay(j, seed) : fcs[8*(3 - (j - p)) +: 8];
            a = get_byte(BUF_BASE + (j / mb) * BUF_STEP + (j % mb));
            if (a != e && bad == 0) begin ab = a; eb = e; end
            if (a != e) bad++;
        end
        chk(bad == 0, "R1 R10 stored payload and checksum", {24'd0, ab}, {24'd0, eb});
        chk(rx_active == (n < ring), "R6 R8 active after frame", {31'd0, rx_active}, {31'd0, n < ring});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!rx_active && !s_ready && !mem_req && !evt_rx_buf && !evt_rx_frame, "R12 reset outputs",
            {27'd0, rx_active, s_ready, mem_req, evt_rx_buf, evt_rx_frame}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 inactive: stream refused, no memory traffic
        init_ring(6);
        begin
            int rdy;
            int r0;
            rdy = 0; r0 = nreq;
            s_valid = 1'b1; s_data = 8'h55; s_last = 1'b1;
            repeat (20) begin @(negedge clk); if (s_ready) rdy++; end
            s_valid = 1'b0; s_last = 1'b0;
            chk(rdy == 0 && nreq == r0, "R9 no accept while inactive", 32'(rdy + nreq - r0), 32'd0);
        end

        // R8 activate ignored while disabled
        pulse_load_activate();
        chk(rx_active == 1'b0, "R8 activate with enable low", {31'd0, rx_active}, 32'd0);
        enable = 1'b1;

        // R11 ring_load uses the word-address base
        cfg_ring_base = 30'(DESC_BASE >> 2);

        for (int v = 0; v < 10; v++) begin
            run_vector(int'(VECS[v][63:48]), int'(VECS[v][47:32]), int'(VECS[v][31:16]),
                       int'(VECS[v][15:0]), v * 17 + 3);
        end

        // R7 descriptor owned by software in mid-frame
        begin
            int b0, f0;
            logic [31:0] w0, w1;
            init_ring(6);
            mem[(DESC_BASE + 8) >> 2] = 32'd0;
            cfg_max_buf_blocks = 7'd2;
            pulse_load_activate();
            b0 = nb; f0 = nf;
            send_frame(100, 5);
            repeat (30) @(negedge clk);
            w0 = mem[DESC_BASE >> 2];
            w1 = mem[(DESC_BASE + 8) >> 2];
            chk(w0 == {16'h0000, 16'd32}, "R7 first buffer closed mid-frame", w0, {16'h0000, 16'd32});
            chk(w1 == 32'd0, "R7 owned descriptor untouched", w1, 32'd0);
            chk(nb - b0 == 1 && nf == f0, "R7 no frame event", 32'((nf - f0) * 256 + nb - b0), 32'd1);
            chk(mem[(DESC_BASE + 16) >> 2] == 32'h80000000, "R7 later descriptor untouched",
                mem[(DESC_BASE + 16) >> 2], 32'h80000000);
            chk(rx_active == 1'b0, "R8 inactive after reaching owned descriptor", {31'd0, rx_active}, 32'd0);
        end

        // R8 enable low clears the flag
        init_ring(6);
        pulse_load_activate();
        chk(rx_active == 1'b1, "R8 reactivated", {31'd0, rx_active}, 32'd1);
        enable = 1'b0;
        @(negedge clk);
        chk(rx_active == 1'b0, "R8 cleared by enable low", {31'd0, rx_active}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule